// File: doc/BRIEF.md
# Trigger Input Controller

This block sits between four active-high trigger keys and a playback sequencer. Each raw key is filtered by its own debouncer, which counts sample-rate ticks and accepts a new level only after it has been seen on enough consecutive ticks. The filtered press and release events are then turned into start and abort commands for the sequencer. Each key has its own set of modes:

- a short or a long debounce window;
- edge or level triggering;
- stop-on-release or play-to-end;
- restart-on-press or ignore-while-playing.

When several presses land on the same tick, a fixed priority picks one of them. A force option, together with a status flag from the sequencer, can turn a quick, non-restarting key into a slow, restarting one while audio is playing.

The sequencer reports whether it is playing through `busy`. It is expected to raise `busy` on the cycle after a start and to drop it when it is aborted or reaches the end of a sentence. The controller reports the key that owns playback on `key_idx`. It issues single-cycle `start_pulse` and `abort_pulse` commands and drives `hold_level` while a stop-on-release key is being held. Key 0 has the lowest priority and key 3 the highest.

Top module: `trig_input_ctrl`

## Requirements
- R1: A change on a raw key is accepted only after it has been sampled on FAST_TICKS consecutive `tick` cycles, or SLOW_TICKS when the key's `cfg_slow` bit is set. A sample that agrees with the current accepted level clears the count. Shorter glitches produce no command.
- R2: When a key press is accepted while the controller is idle (`busy` low and no start awaiting `busy`), `start_pulse` is high for exactly one cycle, one clock after the accepting tick. `key_idx` takes that key's index in the same cycle and changes at no other time.
- R3: In edge mode (`cfg_level` bit 0), one press gives exactly one start, whether the press is shorter or longer than the playback.
- R4: In level mode (`cfg_level` bit 1), while the owning key stays pressed, a new start is issued each time `busy` falls. After release, the sentence that is playing finishes and no further start follows.
- R5: With `cfg_hold` set, an accepted release of the owning key during playback gives one `abort_pulse`. With `cfg_hold` clear, a release gives no abort. `hold_level` is high while the owning key has `cfg_hold` set, is held, and owns playback.
- R6: A key with `cfg_retrig` clear that is pressed during playback produces no start and no abort.
- R7: A key with `cfg_retrig` set that is pressed during playback gives an `abort_pulse`, followed on the next cycle by a `start_pulse` for that key. This applies even when a different key owns playback (last-key priority).
- R8: When presses on several keys are accepted on the same tick, the highest index wins (3 > 2 > 1 > 0).
- R9: The force condition holds when a key has `cfg_force` set, `cfg_slow` clear and `cfg_retrig` clear, and `status_flag` reads 0 while `busy` is high. Under that condition the key uses the slow debounce window and restart-on-press behaviour. With `status_flag` at 1, or while idle, its configured modes apply.
- R10: `start_pulse` and `abort_pulse` are never high in the same cycle. When a restart press and a stop-on-release release are accepted on the same tick, the restart wins.
- R11: During and straight after reset, `start_pulse`, `abort_pulse`, `hold_level` and `key_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-rate strobe, one cycle wide |
| key_raw | input | KEYS | Raw active-high trigger keys |
| busy | input | 1 | Sequencer is playing |
| status_flag | input | 1 | Status bit gating the force option |
| cfg_slow | input | KEYS | Per key: long debounce window |
| cfg_level | input | KEYS | Per key: level triggering |
| cfg_hold | input | KEYS | Per key: stop on release |
| cfg_retrig | input | KEYS | Per key: restart on press during playback |
| cfg_force | input | KEYS | Per key: enable the force option |
| key_idx | output | IDX_W | Index of the key owning playback |
| start_pulse | output | 1 | Start the sentence of `key_idx` |
| abort_pulse | output | 1 | Stop playback now |
| hold_level | output | 1 | Owning stop-on-release key is held |

## Verification
Two functions can fall in the same cycle: the release of a stop-on-release key and the accepted press of a restarting key. Both would issue an abort. The bench provokes this by changing both raw keys on the same clock with the same debounce window, so that both filtered events come out of the same tick. It then checks two things: that exactly one abort is followed by one start for the new key, and that the cycle-by-cycle reference model agrees on every output. The checker also forbids any cycle in which start and abort are both high.

// File: rtl/trig_pkg.sv
package trig_pkg;

  parameter int unsigned KEYS  = 4;
  parameter int unsigned IDX_W = $clog2(KEYS);

  typedef logic [IDX_W-1:0] key_idx_t;

  // Force rule: a quick, non-restarting key switches to slow/restart
  // while playback is running and the status bit reads low.
  function automatic logic force_hit(input logic fen, input logic slow,
                                     input logic retrig, input logic busy,
                                     input logic flag);
    return fen & ~slow & ~retrig & busy & ~flag;
  endfunction

  // Returns {valid, index}; a higher index overrides a lower one.
  function automatic logic [IDX_W:0] top_pick(input logic [KEYS-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = 0; i < KEYS; i++) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

endpackage

// File: rtl/trig_debounce.sv
module trig_debounce #(
  parameter int unsigned FAST_TICKS = 2,
  parameter int unsigned SLOW_TICKS = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sample,
  input  logic slow_sel,
  output logic level_q,
  output logic rise_q,
  output logic fall_q
);

  localparam int unsigned MAX_TICKS = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  function automatic logic [CNT_W:0] limit_for(input logic slow);
    return slow ? (CNT_W+1)'(SLOW_TICKS) : (CNT_W+1)'(FAST_TICKS);
  endfunction

  logic [CNT_W-1:0] run_q;
  logic [CNT_W:0]   run_next;
  logic             disagree;
  logic             expire;

  assign disagree = (sample != level_q);
  assign run_next = {1'b0, run_q} + 1'b1;
  assign expire   = tick & disagree & (run_next >= limit_for(slow_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (tick) begin
        if (!disagree) begin
          run_q <= '0;
        end else if (expire) begin
          run_q   <= '0;
          level_q <= sample;
          rise_q  <= sample;
          fall_q  <= ~sample;
        end else begin
          run_q <= run_next[CNT_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/trig_play_ctl.sv
module trig_play_ctl
  import trig_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KEYS-1:0] rise_vec,
  input  logic [KEYS-1:0] fall_vec,
  input  logic [KEYS-1:0] level_vec,
  input  logic [KEYS-1:0] retrig_mode,
  input  logic [KEYS-1:0] level_mode,
  input  logic [KEYS-1:0] hold_mode,
  input  logic            busy,
  output logic            start_pulse,
  output logic            abort_pulse,
  output key_idx_t        key_idx,
  output logic            active,
  output logic            retrig_evt,
  output logic            hold_evt
);

  logic [IDX_W:0] pick;
  logic           cand_v;
  key_idx_t       cand;
  logic           wait_q, pend_q, busy_q;
  key_idx_t       pend_idx_q;
  logic           engaged, admit_evt, repeat_evt;
  logic           do_start, do_abort;
  key_idx_t       nxt_idx;

  assign pick    = top_pick(rise_vec);
  assign cand_v  = pick[IDX_W];
  assign cand    = pick[IDX_W-1:0];
  assign engaged = busy | wait_q;

  // Named events in their order of precedence.
  assign admit_evt  = ~pend_q & cand_v & ~engaged;
  assign retrig_evt = ~pend_q & cand_v & engaged & retrig_mode[cand];
  assign hold_evt   = ~pend_q & ~retrig_evt & active & engaged
                      & fall_vec[key_idx] & hold_mode[key_idx];
  assign repeat_evt = ~pend_q & ~admit_evt & active & ~engaged
                      & level_mode[key_idx] & level_vec[key_idx];

  always_comb begin
    do_start = 1'b0;
    do_abort = 1'b0;
    nxt_idx  = key_idx;
    if (pend_q) begin
      do_start = 1'b1;
      nxt_idx  = pend_idx_q;
    end else if (admit_evt) begin
      do_start = 1'b1;
      nxt_idx  = cand;
    end else if (retrig_evt || hold_evt) begin
      do_abort = 1'b1;
    end else if (repeat_evt) begin
      do_start = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      abort_pulse <= 1'b0;
      key_idx     <= '0;
      active      <= 1'b0;
      wait_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_idx_q  <= '0;
      busy_q      <= 1'b0;
    end else begin
      start_pulse <= do_start;
      abort_pulse <= do_abort;
      pend_q      <= retrig_evt;
      busy_q      <= busy;
      if (retrig_evt) pend_idx_q <= cand;
      if (do_start) begin
        key_idx <= nxt_idx;
        active  <= 1'b1;
        wait_q  <= 1'b1;
      end else begin
        if (busy) wait_q <= 1'b0;
        if (hold_evt) active <= 1'b0;
        else if (busy_q && !busy && !retrig_evt) active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/trig_input_ctrl.sv
module trig_input_ctrl
  import trig_pkg::*;
#(
  parameter int unsigned FAST_TICKS = 2,
  parameter int unsigned SLOW_TICKS = 96
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [KEYS-1:0] key_raw,
  input  logic            busy,
  input  logic            status_flag,
  input  logic [KEYS-1:0] cfg_slow,
  input  logic [KEYS-1:0] cfg_level,
  input  logic [KEYS-1:0] cfg_hold,
  input  logic [KEYS-1:0] cfg_retrig,
  input  logic [KEYS-1:0] cfg_force,
  output key_idx_t        key_idx,
  output logic            start_pulse,
  output logic            abort_pulse,
  output logic            hold_level
);

  logic [KEYS-1:0] force_on, slow_eff, retrig_eff;
  logic [KEYS-1:0] rise_vec, fall_vec, level_vec;
  logic            active, retrig_evt, hold_evt;

  for (genvar k = 0; k < KEYS; k++) begin : g_key
    assign force_on[k]   = force_hit(cfg_force[k], cfg_slow[k], cfg_retrig[k],
                                     busy, status_flag);
    assign slow_eff[k]   = cfg_slow[k] | force_on[k];
    assign retrig_eff[k] = cfg_retrig[k] | force_on[k];

    trig_debounce #(
      .FAST_TICKS(FAST_TICKS),
      .SLOW_TICKS(SLOW_TICKS)
    ) u_db (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .sample  (key_raw[k]),
      .slow_sel(slow_eff[k]),
      .level_q (level_vec[k]),
      .rise_q  (rise_vec[k]),
      .fall_q  (fall_vec[k])
    );
  end

  trig_play_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_vec   (rise_vec),
    .fall_vec   (fall_vec),
    .level_vec  (level_vec),
    .retrig_mode(retrig_eff),
    .level_mode (cfg_level),
    .hold_mode  (cfg_hold),
    .busy       (busy),
    .start_pulse(start_pulse),
    .abort_pulse(abort_pulse),
    .key_idx    (key_idx),
    .active     (active),
    .retrig_evt (retrig_evt),
    .hold_evt   (hold_evt)
  );

  assign hold_level = active & cfg_hold[key_idx] & level_vec[key_idx];

endmodule

// File: rtl/trig_input_ctrl_chk.sv
module trig_input_ctrl_chk
  import trig_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            start_pulse,
  input logic            abort_pulse,
  input key_idx_t        key_idx,
  input logic [KEYS-1:0] rise_vec,
  input logic            retrig_evt,
  input logic            hold_evt
);

  AST_START_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && abort_pulse)); // R10

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R2

  AST_IDX_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(key_idx) |-> start_pulse); // R2

  AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_vec) |=> ((rise_vec & $past(rise_vec)) == '0)); // R1

  AST_RETRIG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    retrig_evt |=> abort_pulse ##1 start_pulse); // R7

  AST_HOLD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> (abort_pulse && !start_pulse)); // R5

endmodule

bind trig_input_ctrl trig_input_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_pulse(start_pulse),
  .abort_pulse(abort_pulse),
  .key_idx    (key_idx),
  .rise_vec   (rise_vec),
  .retrig_evt (retrig_evt),
  .hold_evt   (hold_evt)
);

// File: tb/test_trig_input_ctrl.sv
module test_trig_input_ctrl;

  localparam int FT   = 2;
  localparam int ST   = 6;
  localparam int TDIV = 4;
  localparam int LEN  = 150;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       busy = 1'b0;
  logic       status_flag = 1'b1;
  logic [3:0] key_raw = '0;
  logic [3:0] cfg_slow = '0, cfg_level = '0, cfg_hold = '0, cfg_retrig = '0, cfg_force = '0;
  logic [1:0] key_idx;
  logic       start_pulse, abort_pulse, hold_level;

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";

  always #10 clk = ~clk;

  trig_input_ctrl #(.FAST_TICKS(FT), .SLOW_TICKS(ST)) i_trig_input_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .key_raw(key_raw), .busy(busy),
    .status_flag(status_flag), .cfg_slow(cfg_slow), .cfg_level(cfg_level),
    .cfg_hold(cfg_hold), .cfg_retrig(cfg_retrig), .cfg_force(cfg_force),
    .key_idx(key_idx), .start_pulse(start_pulse), .abort_pulse(abort_pulse),
    .hold_level(hold_level)
  );

  // Sample-rate strobe, driven between edges.
  int tdiv = 0;
  always @(posedge clk) begin
    #2;
    tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
  end

  // Behavioural reference model, advanced on each rising edge.
  bit m_lvl[4], m_rise[4], m_fall[4];
  int m_cnt[4];
  bit m_start, m_abort, m_act, m_wait, m_pend, m_busyq;
  int m_idx, m_pidx;

  function automatic bit forced(int k);
    return cfg_force[k] && !cfg_slow[k] && !cfg_retrig[k] && busy && !status_flag;
  endfunction

  task automatic model_step();
    int cand, nidx, lim;
    bit eng, ds, da, sp;
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        m_lvl[k] = 0; m_rise[k] = 0; m_fall[k] = 0; m_cnt[k] = 0;
      end
      m_start = 0; m_abort = 0; m_act = 0; m_wait = 0; m_pend = 0; m_busyq = 0;
      m_idx = 0; m_pidx = 0;
      return;
    end
    eng = busy || m_wait;
    cand = -1;
    for (int k = 3; k >= 0; k--) if (m_rise[k] && cand < 0) cand = k;
    ds = 0; da = 0; sp = 0; nidx = m_idx;
    if (m_pend) begin ds = 1; nidx = m_pidx; end
    else if (cand >= 0 && !eng) begin ds = 1; nidx = cand; end
    else if (cand >= 0 && (cfg_retrig[cand] || forced(cand))) begin da = 1; sp = 1; end
    else if (m_act && eng && m_fall[m_idx] && cfg_hold[m_idx]) da = 1;
    else if (m_act && !eng && cfg_level[m_idx] && m_lvl[m_idx]) ds = 1;
    if (ds) begin m_idx = nidx; m_act = 1; m_wait = 1; end
    else begin
      if (busy) m_wait = 0;
      if (da && !sp) m_act = 0;
      else if (m_busyq && !busy && !sp) m_act = 0;
    end
    if (sp) m_pidx = cand;
    m_pend = sp; m_start = ds; m_abort = da; m_busyq = busy;
    for (int k = 0; k < 4; k++) begin
      m_rise[k] = 0; m_fall[k] = 0;
      lim = (cfg_slow[k] || forced(k)) ? ST : FT;
      if (tick) begin
        if (key_raw[k] == m_lvl[k]) m_cnt[k] = 0;
        else if (m_cnt[k] + 1 >= lim) begin
          m_lvl[k] = key_raw[k]; m_cnt[k] = 0;
          m_rise[k] = key_raw[k]; m_fall[k] = !key_raw[k];
        end else m_cnt[k] = m_cnt[k] + 1;
      end
    end
  endtask

  always @(posedge clk) model_step();

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every cycle, play the sequencer, count commands.
  int n_start = 0, n_abort = 0, last_idx = 0, play_left = 0, cyc = 0;
  bit wd_hit = 0;
  always @(negedge clk) begin
    int exp_vec, act_vec;
    cyc++;
    if (rst_n) begin
      exp_vec = {m_start, m_abort, m_idx[1:0],
                 m_act && cfg_hold[m_idx] && m_lvl[m_idx]};
      act_vec = {start_pulse, abort_pulse, key_idx, hold_level};
      check(exp_vec == act_vec, cur_req, act_vec, exp_vec);
      check(!(start_pulse && abort_pulse), "R10", int'(start_pulse && abort_pulse), 0);
      if (abort_pulse) begin n_abort++; busy = 0; play_left = 0; end
      else if (start_pulse) begin
        n_start++; last_idx = key_idx; busy = 1; play_left = LEN;
      end else if (busy) begin
        play_left--;
        if (play_left <= 0) busy = 0;
      end
    end
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic settle();
    int q;
    key_raw = '0;
    q = 0;
    while (q < 40) begin
      @(posedge clk);
      q = busy ? 0 : q + 1;
    end
    #2;
    cfg_slow = '0; cfg_level = '0; cfg_hold = '0; cfg_retrig = '0; cfg_force = '0;
    status_flag = 1;
  endtask

  initial begin
    int s0, a0;
    clks(5);
    check({start_pulse, abort_pulse, key_idx, hold_level} == 0, "R11",
          {start_pulse, abort_pulse, key_idx, hold_level}, 0);
    rst_n = 1;
    clks(2);
    check({start_pulse, abort_pulse, key_idx, hold_level} == 0, "R11",
          {start_pulse, abort_pulse, key_idx, hold_level}, 0);

    // R1: glitches shorter than the window are dropped
    cur_req = "R1"; s0 = n_start;
    key_raw = 4'b0001; clks(4); key_raw = 0; clks(20);
    cfg_slow = 4'b0010; key_raw = 4'b0010; clks(20); key_raw = 0; clks(30);
    check(n_start == s0, "R1", n_start - s0, 0);
    key_raw = 4'b0010; clks(40); key_raw = 0;
    check(n_start == s0 + 1 && last_idx == 1, "R1", n_start - s0, 1);
    settle();

    // R2 / R3: edge mode, press longer than playback
    cur_req = "R3"; s0 = n_start;
    key_raw = 4'b0001; clks(200); key_raw = 0;
    settle();
    check(n_start == s0 + 1, "R3", n_start - s0, 1);
    check(last_idx == 0, "R2", last_idx, 0);

    // R4: level mode repeats while held
    cur_req = "R4"; s0 = n_start;
    cfg_level = 4'b0100; key_raw = 4'b0100; clks(400); key_raw = 0;
    settle();
    check(n_start - s0 >= 2, "R4", n_start - s0, 2);

    // R5: stop on release, then play to end
    cur_req = "R5"; a0 = n_abort;
    cfg_hold = 4'b1000; key_raw = 4'b1000; clks(30);
    check(hold_level == 1, "R5", hold_level, 1);
    key_raw = 0; clks(30);
    check(n_abort == a0 + 1, "R5", n_abort - a0, 1);
    settle();
    a0 = n_abort;
    key_raw = 4'b1000; clks(30); key_raw = 0; clks(30);
    check(n_abort == a0 && busy, "R5", n_abort - a0, 0);
    settle();

    // R6: second press ignored
    cur_req = "R6"; s0 = n_start; a0 = n_abort;
    key_raw = 4'b0001; clks(20); key_raw = 0; clks(20);
    key_raw = 4'b0001; clks(20); key_raw = 0;
    settle();
    check(n_start == s0 + 1 && n_abort == a0, "R6", n_start - s0, 1);

    // R7: last-key preemption
    cur_req = "R7"; s0 = n_start; a0 = n_abort;
    cfg_retrig = 4'b0110; key_raw = 4'b0100; clks(20); key_raw = 0; clks(20);
    key_raw = 4'b0010; clks(20); key_raw = 0;
    settle();
    check(n_abort == a0 + 1 && n_start == s0 + 2, "R7", n_start - s0, 2);
    check(last_idx == 1, "R7", last_idx, 1);

    // R8: simultaneous presses
    cur_req = "R8";
    key_raw = 4'b1011; clks(20); key_raw = 0;
    settle();
    check(last_idx == 3, "R8", last_idx, 3);

    // R9: force rule with status low, then high
    cur_req = "R9"; s0 = n_start; a0 = n_abort;
    cfg_force = 4'b0001; status_flag = 0;
    key_raw = 4'b0001; clks(20); key_raw = 0; clks(40);
    key_raw = 4'b0001; clks(40); key_raw = 0;
    settle();
    check(n_abort == a0 + 1 && n_start == s0 + 2, "R9", n_start - s0, 2);
    s0 = n_start; a0 = n_abort;
    cfg_force = 4'b0001; status_flag = 1;
    key_raw = 4'b0001; clks(20); key_raw = 0; clks(40);
    key_raw = 4'b0001; clks(40); key_raw = 0;
    settle();
    check(n_abort == a0 && n_start == s0 + 1, "R9", n_start - s0, 1);

    // R10: release of a hold key and a restart press on the same tick
    cur_req = "R10"; s0 = n_start; a0 = n_abort;
    cfg_hold = 4'b1000; cfg_retrig = 4'b0100;
    key_raw = 4'b1000; clks(30);
    key_raw = 4'b0100; clks(30); key_raw = 0;
    settle();
    check(n_abort == a0 + 1 && n_start == s0 + 2, "R10", n_start - s0, 2);
    check(last_idx == 2, "R10", last_idx, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule